// File: doc/BRIEF.md
# Cache Miss-Tracking Entry with Deferred Targets

This block is one miss-holding entry of a coherent cache. When a line misses, the entry is allocated with the line address, an order tag, a ready time and the first request. It then keeps every later request to that line as a small descriptor: command, source side, order tag and ready time. The descriptors sit in two fixed-depth target queues, the primary queue and the deferred queue. A request that conflicts with the one already sent downstream waits in the deferred queue. After the fill has been drained, the two queues swap roles and the deferred group is issued again.

The entry also judges bus snoops against its own outstanding request. Before issue, a snoop only makes it turn buffered upgrades into read-exclusive requests. After issue, a snoop can produce inhibit and supply-exclusive hints, a shared hint, or a pending invalidate that sends all later requests to the deferred queue. Operations arrive one per cycle on an opcode input. The entry moves through four named states: IDLE (free), WAIT (allocated, not yet issued), SERVICE (request outstanding) and DRAIN (fill returned, targets being popped). The transitions are:

- alloc: IDLE to WAIT.
- issue: WAIT to SERVICE, or WAIT to IDLE when the entry is a forward-only entry.
- fill: SERVICE to DRAIN.
- promote: DRAIN to WAIT.
- free: any state to IDLE.

Top module: `miss_entry`

## Requirements
- R1: An alloc op (op_i=1) in IDLE stores line address, order tag and ready time, clears the pending-invalidate, pending-shared and downstream-pending flags, places the request (cpu side) in the primary queue, sets the target count to 1 and enters WAIT (state_o=1); state codes are IDLE=0, WAIT=1, SERVICE=2, DRAIN=3.
- R2: An add op (op_i=2) goes to the deferred queue only when the entry is in service (SERVICE or DRAIN) and the deferred queue is non-empty, or pending invalidate is set, or the new command needs exclusive while the primary queue does not. Otherwise it goes to the primary queue. The count increments either way. Commands are READ=0, READ_EX=1, UPGRADE=2, WRITE=3, and all except READ need exclusive.
- R3: A request or snoop copy aimed at a full queue raises stall_o in that cycle and changes neither queue nor count.
- R4: An issue op (op_i=3) in WAIT on a forward-only entry holding exactly one target pops it, pulses issue_free_o and returns to IDLE with count 0. Otherwise it enters SERVICE.
- R5: A snoop op (op_i=4) seen in WAIT gives no hints and appends nothing. If the snoop needs exclusive, every cpu-side UPGRADE in both queues becomes READ_EX.
- R6: In service, an exclusive snoop rewrites upgrades in the deferred queue only. Once pending invalidate is set, any further snoop is absorbed (snp_hit_o=1) with no hint and no append.
- R7: In service, when the primary queue or the snoop needs exclusive, a memory-side copy of the snoop (cpu=0) is appended to the primary queue. Inhibit and supply-exclusive are raised only if the primary queue needs exclusive, and pending invalidate is set if the snoop needs exclusive.
- R8: In service, a read snoop meeting a non-exclusive primary queue raises snp_shared_o and sets pending shared. The later fill op (op_i=5) then raises fill_shared_o.
- R9: A promote op (op_i=7) in DRAIN with an empty primary and non-empty deferred queue swaps the queues, clears the new deferred queue's flags and both pending flags, takes the order tag from the new head, sets ready time to the maximum of now_i and the head's ready time, pulses promote_ok_o and enters WAIT.
- R10: A free op (op_i=8) is accepted (state IDLE, count 0) only with both queues empty, deferred flags clear and count zero. Otherwise dealloc_err_o is raised and nothing changes.
- R11: An express snoop while downstream pending is set (dn_pend_i seen since allocation) is treated as if the entry were not in service.
- R12: A pop op (op_i=6) in DRAIN removes the primary head in FIFO order and decrements the count. The head fields are visible on head_* while head_valid_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_i | input | 4 | Operation: 0 nop, 1 alloc, 2 add, 3 issue, 4 snoop, 5 fill, 6 pop, 7 promote, 8 free |
| addr_i | input | ADDR_W | Line address for alloc |
| fwd_i | input | 1 | Alloc marks a forward-only entry |
| cmd_i | input | 2 | Command of the request for alloc/add |
| order_i | input | ORD_W | Order tag of the request or snoop |
| ready_i | input | TIME_W | Ready time of the request |
| now_i | input | TIME_W | Current time |
| snp_cmd_i | input | 2 | Command of the snoop |
| snp_express_i | input | 1 | Snoop is an express snoop |
| dn_pend_i | input | 1 | Marks the request as still buffered downstream |
| state_o | output | 2 | Entry state code |
| line_addr_o | output | ADDR_W | Stored line address |
| order_o | output | ORD_W | Entry order tag |
| ready_o | output | TIME_W | Entry ready time |
| tgt_count_o | output | CNT_W | Targets held in both queues |
| head_valid_o | output | 1 | Primary queue non-empty |
| head_cmd_o | output | 2 | Primary head command |
| head_cpu_o | output | 1 | Primary head came from the cpu side |
| head_order_o | output | ORD_W | Primary head order tag |
| stall_o | output | 1 | Target refused, queue full |
| issue_free_o | output | 1 | Issue completed a forward-only entry |
| snp_hit_o | output | 1 | Snoop handled by the entry |
| snp_inhibit_o | output | 1 | Memory response inhibited for snoop |
| snp_supply_excl_o | output | 1 | Entry will supply an exclusive copy |
| snp_shared_o | output | 1 | Snoop requester must treat line as shared |
| fill_shared_o | output | 1 | Fill response to be marked shared |
| promote_ok_o | output | 1 | Deferred queue promoted |
| dealloc_err_o | output | 1 | Free refused, entry not clean |

## Verification
The bench targets the placement rule at its edges: an exclusive request behind a read already in service, a read behind a non-empty deferred queue, and a read arriving after an exclusive snoop. A design that put any of these in the primary queue would show a valid head after the first group is popped. Upgrade rewriting is checked for scope. It must not touch the primary queue in service, and it must touch both queues before issue, so a wrong scope shows up in the head command after the fill. The bench also drives pending-shared leaking past a promotion, a forward-only entry that fails to free, a full queue that overwrites an entry, and an early free that slips through. Each of these shows a wrong hint, count or state code.

// File: rtl/miss_entry_pkg.sv
package miss_entry_pkg;

    parameter int ORD_W  = 8;
    parameter int TIME_W = 16;

    typedef enum logic [1:0] {
        CMD_READ    = 2'd0,
        CMD_READ_EX = 2'd1,
        CMD_UPGRADE = 2'd2,
        CMD_WRITE   = 2'd3
    } cmd_e;

    typedef enum logic [3:0] {
        OP_NOP     = 4'd0,
        OP_ALLOC   = 4'd1,
        OP_ADD     = 4'd2,
        OP_ISSUE   = 4'd3,
        OP_SNOOP   = 4'd4,
        OP_FILL    = 4'd5,
        OP_POP     = 4'd6,
        OP_PROMOTE = 4'd7,
        OP_FREE    = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WAIT    = 2'd1,
        ST_SERVICE = 2'd2,
        ST_DRAIN   = 2'd3
    } st_e;

    typedef struct packed {
        cmd_e              cmd;
        logic              cpu;
        logic [ORD_W-1:0]  order;
        logic [TIME_W-1:0] ready;
    } tgt_t;

    function automatic logic wants_excl(cmd_e c);
        return c != CMD_READ;
    endfunction

endpackage

// File: rtl/tgt_fifo.sv
module tgt_fifo
    import miss_entry_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push,
    input  tgt_t push_d,
    input  logic pop,
    input  logic repl_upg,
    input  logic clr_flags,
    output tgt_t head,
    output logic empty,
    output logic full,
    output logic needs_ex,
    output logic has_upg
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    tgt_t          slots [DEPTH];
    logic [PW-1:0] rd_ptr;
    logic [PW-1:0] wr_ptr;
    logic [CW-1:0] fill_cnt;
    logic          do_push;
    logic          do_pop;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (fill_cnt == '0);
    assign full    = (fill_cnt == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   fill_cnt <= fill_cnt + 1'b1;
                2'b01:   fill_cnt <= fill_cnt - 1'b1;
                default: fill_cnt <= fill_cnt;
            endcase
        end
    end

    // Upgrade rewrite covers every slot; only valid ones are ever read.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (repl_upg && has_upg && slots[i].cmd == CMD_UPGRADE)
                slots[i].cmd <= CMD_READ_EX;
        end
        if (do_push) slots[wr_ptr] <= push_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            needs_ex <= 1'b0;
            has_upg  <= 1'b0;
        end else begin
            if (clr_flags) begin
                needs_ex <= 1'b0;
                has_upg  <= 1'b0;
            end
            if (repl_upg) has_upg <= 1'b0;
            if (do_push && push_d.cpu) begin
                if (wants_excl(push_d.cmd))        needs_ex <= 1'b1;
                if (push_d.cmd == CMD_UPGRADE)     has_upg  <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/miss_ctrl.sv
module miss_ctrl
    import miss_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(2 * DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fwd_i,
    input  cmd_e              cmd_i,
    input  logic [ORD_W-1:0]  order_i,
    input  logic [TIME_W-1:0] ready_i,
    input  logic [TIME_W-1:0] now_i,
    input  cmd_e              snp_cmd_i,
    input  logic              snp_express_i,
    input  logic              dn_pend_i,
    input  logic              p_empty,
    input  logic              p_full,
    input  logic              p_nex,
    input  logic              d_empty,
    input  logic              d_full,
    input  logic              d_nex,
    input  logic              d_hup,
    input  logic [ORD_W-1:0]  d_head_order,
    input  logic [TIME_W-1:0] d_head_ready,
    output logic              sel,
    output logic              p_push,
    output logic              d_push,
    output tgt_t              push_d,
    output logic              p_pop,
    output logic              p_repl,
    output logic              d_repl,
    output logic              p_clr,
    output st_e               state,
    output logic [ADDR_W-1:0] line_addr,
    output logic [ORD_W-1:0]  ent_order,
    output logic [TIME_W-1:0] ent_ready,
    output logic [CNT_W-1:0]  tgt_count,
    output logic              stall,
    output logic              issue_free,
    output logic              snp_hit,
    output logic              snp_inhibit,
    output logic              snp_supply_excl,
    output logic              snp_shared,
    output logic              fill_shared,
    output logic              promote_ok,
    output logic              dealloc_err
);
    st_e  state_n;
    logic fwd_q, pend_inv, pend_shr, dn_pend;
    logic ld_alloc, cnt_inc, cnt_dec, set_inv, set_shr, swap;
    logic in_svc, defer, snp_x, passive;

    assign in_svc = (state == ST_SERVICE) || (state == ST_DRAIN);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and per-cycle controls
    always_comb begin
        state_n         = state;
        p_push          = 1'b0;
        d_push          = 1'b0;
        push_d          = '{cmd: cmd_i, cpu: 1'b1, order: order_i, ready: ready_i};
        p_pop           = 1'b0;
        p_repl          = 1'b0;
        d_repl          = 1'b0;
        p_clr           = 1'b0;
        ld_alloc        = 1'b0;
        cnt_inc         = 1'b0;
        cnt_dec         = 1'b0;
        set_inv         = 1'b0;
        set_shr         = 1'b0;
        swap            = 1'b0;
        stall           = 1'b0;
        issue_free      = 1'b0;
        snp_hit         = 1'b0;
        snp_inhibit     = 1'b0;
        snp_supply_excl = 1'b0;
        snp_shared      = 1'b0;
        fill_shared     = 1'b0;
        promote_ok      = 1'b0;
        dealloc_err     = 1'b0;
        defer           = in_svc && (!d_empty || pend_inv || (!p_nex && wants_excl(cmd_i)));
        snp_x           = wants_excl(snp_cmd_i);
        passive         = !in_svc || (snp_express_i && dn_pend);
        unique case (op)
            OP_ALLOC: begin
                if (state == ST_IDLE) begin
                    p_push   = 1'b1;
                    ld_alloc = 1'b1;
                    state_n  = ST_WAIT;
                end
            end
            OP_ADD: begin
                if (state != ST_IDLE) begin
                    if (defer ? d_full : p_full) begin
                        stall = 1'b1;
                    end else begin
                        d_push  = defer;
                        p_push  = !defer;
                        cnt_inc = 1'b1;
                    end
                end
            end
            OP_ISSUE: begin
                if (state == ST_WAIT) begin
                    if (fwd_q && tgt_count == CNT_W'(1)) begin
                        p_pop      = 1'b1;
                        p_clr      = 1'b1;
                        cnt_dec    = 1'b1;
                        issue_free = 1'b1;
                        state_n    = ST_IDLE;
                    end else begin
                        state_n = ST_SERVICE;
                    end
                end
            end
            OP_SNOOP: begin
                if (state != ST_IDLE) begin
                    if (passive) begin
                        p_repl = snp_x;
                        d_repl = snp_x;
                    end else begin
                        d_repl = snp_x;
                        if (pend_inv) begin
                            snp_hit = 1'b1;
                        end else if (p_nex || snp_x) begin
                            if (p_full) begin
                                stall = 1'b1;
                            end else begin
                                p_push          = 1'b1;
                                push_d          = '{cmd: snp_cmd_i, cpu: 1'b0,
                                                    order: order_i, ready: now_i};
                                cnt_inc         = 1'b1;
                                snp_hit         = 1'b1;
                                snp_inhibit     = p_nex;
                                snp_supply_excl = p_nex;
                                set_inv         = snp_x;
                            end
                        end else begin
                            snp_hit    = 1'b1;
                            snp_shared = 1'b1;
                            set_shr    = 1'b1;
                        end
                    end
                end
            end
            OP_FILL: begin
                if (state == ST_SERVICE) begin
                    fill_shared = pend_shr;
                    state_n     = ST_DRAIN;
                end
            end
            OP_POP: begin
                if (state == ST_DRAIN && !p_empty) begin
                    p_pop   = 1'b1;
                    cnt_dec = 1'b1;
                end
            end
            OP_PROMOTE: begin
                if (state == ST_DRAIN && p_empty && !d_empty) begin
                    swap       = 1'b1;
                    p_clr      = 1'b1;
                    promote_ok = 1'b1;
                    state_n    = ST_WAIT;
                end
            end
            OP_FREE: begin
                if (p_empty && d_empty && !d_nex && !d_hup && tgt_count == '0) begin
                    p_clr   = 1'b1;
                    state_n = ST_IDLE;
                end else begin
                    dealloc_err = 1'b1;
                end
            end
            default: begin
            end
        endcase
    end

    // entry record
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel       <= 1'b0;
            line_addr <= '0;
            ent_order <= '0;
            ent_ready <= '0;
            tgt_count <= '0;
            fwd_q     <= 1'b0;
            pend_inv  <= 1'b0;
            pend_shr  <= 1'b0;
            dn_pend   <= 1'b0;
        end else begin
            if (ld_alloc) begin
                line_addr <= addr_i;
                ent_order <= order_i;
                ent_ready <= ready_i;
                fwd_q     <= fwd_i;
                tgt_count <= CNT_W'(1);
                pend_inv  <= 1'b0;
                pend_shr  <= 1'b0;
                dn_pend   <= 1'b0;
            end else begin
                if (cnt_inc) tgt_count <= tgt_count + 1'b1;
                if (cnt_dec) tgt_count <= tgt_count - 1'b1;
                if (set_inv) pend_inv <= 1'b1;
                if (set_shr) pend_shr <= 1'b1;
                if (dn_pend_i && state != ST_IDLE) dn_pend <= 1'b1;
                if (swap) begin
                    sel       <= ~sel;
                    pend_inv  <= 1'b0;
                    pend_shr  <= 1'b0;
                    ent_order <= d_head_order;
                    ent_ready <= (now_i > d_head_ready) ? now_i : d_head_ready;
                end
            end
        end
    end

endmodule

// File: rtl/miss_entry.sv
module miss_entry
    import miss_entry_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(2 * DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              fwd_i,
    input  logic [1:0]        cmd_i,
    input  logic [ORD_W-1:0]  order_i,
    input  logic [TIME_W-1:0] ready_i,
    input  logic [TIME_W-1:0] now_i,
    input  logic [1:0]        snp_cmd_i,
    input  logic              snp_express_i,
    input  logic              dn_pend_i,
    output logic [1:0]        state_o,
    output logic [ADDR_W-1:0] line_addr_o,
    output logic [ORD_W-1:0]  order_o,
    output logic [TIME_W-1:0] ready_o,
    output logic [CNT_W-1:0]  tgt_count_o,
    output logic              head_valid_o,
    output logic [1:0]        head_cmd_o,
    output logic              head_cpu_o,
    output logic [ORD_W-1:0]  head_order_o,
    output logic              stall_o,
    output logic              issue_free_o,
    output logic              snp_hit_o,
    output logic              snp_inhibit_o,
    output logic              snp_supply_excl_o,
    output logic              snp_shared_o,
    output logic              fill_shared_o,
    output logic              promote_ok_o,
    output logic              dealloc_err_o
);
    logic sel, p_push, d_push, p_pop, p_repl, d_repl, p_clr;
    tgt_t push_d;
    st_e  state;
    tgt_t q_head  [2];
    logic q_empty [2];
    logic q_full  [2];
    logic q_nex   [2];
    logic q_hup   [2];
    tgt_t p_head, d_head;

    // Two physical queues; sel names the one acting as primary.
    for (genvar g = 0; g < 2; g++) begin : g_q
        logic is_p;
        assign is_p = (sel == 1'(g));
        tgt_fifo #(.DEPTH(DEPTH)) u_q (
            .clk      (clk),
            .rst_n    (rst_n),
            .push     (is_p ? p_push : d_push),
            .push_d   (push_d),
            .pop      (is_p && p_pop),
            .repl_upg (is_p ? p_repl : d_repl),
            .clr_flags(is_p && p_clr),
            .head     (q_head[g]),
            .empty    (q_empty[g]),
            .full     (q_full[g]),
            .needs_ex (q_nex[g]),
            .has_upg  (q_hup[g])
        );
    end

    assign p_head = q_head[sel];
    assign d_head = q_head[~sel];

    miss_ctrl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .op             (op_e'(op_i)),
        .addr_i         (addr_i),
        .fwd_i          (fwd_i),
        .cmd_i          (cmd_e'(cmd_i)),
        .order_i        (order_i),
        .ready_i        (ready_i),
        .now_i          (now_i),
        .snp_cmd_i      (cmd_e'(snp_cmd_i)),
        .snp_express_i  (snp_express_i),
        .dn_pend_i      (dn_pend_i),
        .p_empty        (q_empty[sel]),
        .p_full         (q_full[sel]),
        .p_nex          (q_nex[sel]),
        .d_empty        (q_empty[~sel]),
        .d_full         (q_full[~sel]),
        .d_nex          (q_nex[~sel]),
        .d_hup          (q_hup[~sel]),
        .d_head_order   (d_head.order),
        .d_head_ready   (d_head.ready),
        .sel            (sel),
        .p_push         (p_push),
        .d_push         (d_push),
        .push_d         (push_d),
        .p_pop          (p_pop),
        .p_repl         (p_repl),
        .d_repl         (d_repl),
        .p_clr          (p_clr),
        .state          (state),
        .line_addr      (line_addr_o),
        .ent_order      (order_o),
        .ent_ready      (ready_o),
        .tgt_count      (tgt_count_o),
        .stall          (stall_o),
        .issue_free     (issue_free_o),
        .snp_hit        (snp_hit_o),
        .snp_inhibit    (snp_inhibit_o),
        .snp_supply_excl(snp_supply_excl_o),
        .snp_shared     (snp_shared_o),
        .fill_shared    (fill_shared_o),
        .promote_ok     (promote_ok_o),
        .dealloc_err    (dealloc_err_o)
    );

    assign state_o      = state;
    assign head_valid_o = !q_empty[sel];
    assign head_cmd_o   = p_head.cmd;
    assign head_cpu_o   = p_head.cpu;
    assign head_order_o = p_head.order;

endmodule

// File: rtl/miss_entry_chk.sv
module miss_entry_chk #(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(2 * DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [3:0]       op_i,
    input logic [1:0]       state_o,
    input logic [CNT_W-1:0] tgt_count_o,
    input logic             stall_o,
    input logic             issue_free_o,
    input logic             snp_inhibit_o,
    input logic             snp_shared_o,
    input logic             promote_ok_o,
    input logic             dealloc_err_o
);
    a_r1_alloc_one: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd1 && state_o == 2'd0) |=> (state_o == 2'd1 && tgt_count_o == CNT_W'(1)));

    a_r3_stall_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |=> $stable(tgt_count_o));

    a_r4_forward_frees: assert property (@(posedge clk) disable iff (!rst_n)
        issue_free_o |=> (state_o == 2'd0 && tgt_count_o == '0));

    a_r7_inhibit_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit_o |-> state_o[1]);

    a_r8_shared_not_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        snp_shared_o |-> !snp_inhibit_o);

    a_r9_promote_waits: assert property (@(posedge clk) disable iff (!rst_n)
        promote_ok_o |=> state_o == 2'd1);

    a_r10_free_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd8 && !dealloc_err_o) |=> (state_o == 2'd0 && tgt_count_o == '0));

    a_r10_error_holds: assert property (@(posedge clk) disable iff (!rst_n)
        dealloc_err_o |=> $stable(state_o));

    a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_count_o <= CNT_W'(2 * DEPTH));

endmodule

bind miss_entry miss_entry_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_i         (op_i),
    .state_o      (state_o),
    .tgt_count_o  (tgt_count_o),
    .stall_o      (stall_o),
    .issue_free_o (issue_free_o),
    .snp_inhibit_o(snp_inhibit_o),
    .snp_shared_o (snp_shared_o),
    .promote_ok_o (promote_ok_o),
    .dealloc_err_o(dealloc_err_o)
);

// File: tb/miss_entry_test.sv
module miss_entry_test;
    import miss_entry_pkg::*;

    localparam int ADDR_W = 32;
    localparam int DEPTH  = 4;
    localparam int CNT_W  = $clog2(2 * DEPTH + 1);

    localparam int P_STATE = 0, P_CNT = 1, P_STALL = 2, P_FREE = 3, P_HIT = 4,
                   P_INH = 5, P_SUP = 6, P_SHR = 7, P_FSHR = 8, P_PROK = 9,
                   P_ERR = 10, P_HV = 11, P_HCMD = 12, P_HCPU = 13, P_HORD = 14,
                   P_ORD = 15, P_RDY = 16, P_ADDR = 17;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]        op_i = '0;
    logic [ADDR_W-1:0] addr_i = '0;
    logic              fwd_i = 1'b0;
    logic [1:0]        cmd_i = '0;
    logic [ORD_W-1:0]  order_i = '0;
    logic [TIME_W-1:0] ready_i = '0;
    logic [TIME_W-1:0] now_i = '0;
    logic [1:0]        snp_cmd_i = '0;
    logic              snp_express_i = 1'b0;
    logic              dn_pend_i = 1'b0;
    logic [1:0]        state_o;
    logic [ADDR_W-1:0] line_addr_o;
    logic [ORD_W-1:0]  order_o;
    logic [TIME_W-1:0] ready_o;
    logic [CNT_W-1:0]  tgt_count_o;
    logic              head_valid_o, head_cpu_o;
    logic [1:0]        head_cmd_o;
    logic [ORD_W-1:0]  head_order_o;
    logic stall_o, issue_free_o, snp_hit_o, snp_inhibit_o, snp_supply_excl_o;
    logic snp_shared_o, fill_shared_o, promote_ok_o, dealloc_err_o;

    always #2.5 clk = ~clk;

    miss_entry #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) uut (.*);

    typedef struct {
        int    id;
        int    val;
        string req;
    } item_t;

    item_t exp_q[$];
    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;

    function automatic int probe(int id);
        case (id)
            P_STATE: return int'(state_o);
            P_CNT:   return int'(tgt_count_o);
            P_STALL: return int'(stall_o);
            P_FREE:  return int'(issue_free_o);
            P_HIT:   return int'(snp_hit_o);
            P_INH:   return int'(snp_inhibit_o);
            P_SUP:   return int'(snp_supply_excl_o);
            P_SHR:   return int'(snp_shared_o);
            P_FSHR:  return int'(fill_shared_o);
            P_PROK:  return int'(promote_ok_o);
            P_ERR:   return int'(dealloc_err_o);
            P_HV:    return int'(head_valid_o);
            P_HCMD:  return int'(head_cmd_o);
            P_HCPU:  return int'(head_cpu_o);
            P_HORD:  return int'(head_order_o);
            P_ORD:   return int'(order_o);
            P_RDY:   return int'(ready_o);
            P_ADDR:  return int'(line_addr_o);
            default: return -1;
        endcase
    endfunction

    // monitor: compares queued expectations shortly after the driving edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                item_t it;
                it = exp_q.pop_front();
                vectors++;
                if (probe(it.id) != it.val) begin
                    miscompares++;
                    $display("FAIL %s: probe %0d actual %0d expected %0d",
                             it.req, it.id, probe(it.id), it.val);
                end
            end
        end
    end

    task automatic chk(int id, int val, string req);
        item_t it;
        it.id = id;
        it.val = val;
        it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic go(int op, int cmd = 0, int ord = 0, int rdy = 0, int nw = 0,
                      int scmd = 0, bit ex = 0, bit fw = 0, bit dp = 0, int adr = 0);
        @(negedge clk);
        op_i          = 4'(op);
        cmd_i         = 2'(cmd);
        order_i       = ORD_W'(ord);
        ready_i       = TIME_W'(rdy);
        now_i         = TIME_W'(nw);
        snp_cmd_i     = 2'(scmd);
        snp_express_i = ex;
        fwd_i         = fw;
        dn_pend_i     = dp;
        addr_i        = ADDR_W'(adr);
    endtask

    task automatic idle_chk_state(int st, int cnt, string req);
        go(0);
        chk(P_STATE, st, req);
        chk(P_CNT, cnt, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        go(0);
        chk(P_STATE, 0, "R1 reset");
        chk(P_CNT, 0, "R1 reset");

        // A: read-read sharing, deferral, promotion
        go(1, .cmd(0), .ord(5), .rdy(20), .adr('h1000));
        go(0);
        chk(P_STATE, 1, "R1"); chk(P_CNT, 1, "R1"); chk(P_ORD, 5, "R1");
        chk(P_RDY, 20, "R1"); chk(P_ADDR, 'h1000, "R1");
        go(3);
        idle_chk_state(2, 1, "R4 issue to service");
        go(4, .scmd(0));
        chk(P_HIT, 1, "R8"); chk(P_SHR, 1, "R8"); chk(P_INH, 0, "R8");
        go(2, .cmd(1), .ord(6), .rdy(30));
        go(2, .cmd(0), .ord(7), .rdy(31));
        idle_chk_state(2, 3, "R2 count");
        go(5);
        chk(P_FSHR, 1, "R8 fill shared");
        go(0);
        chk(P_STATE, 3, "R12"); chk(P_HCMD, 0, "R12"); chk(P_HORD, 5, "R12");
        chk(P_HCPU, 1, "R12");
        go(8);
        chk(P_ERR, 1, "R10 early free");
        go(6);
        go(0);
        chk(P_CNT, 2, "R12 pop"); chk(P_HV, 0, "R2 deferred"); chk(P_STATE, 3, "R10 kept");
        go(7, .nw(50));
        chk(P_PROK, 1, "R9");
        go(0);
        chk(P_STATE, 1, "R9"); chk(P_ORD, 6, "R9"); chk(P_RDY, 50, "R9 max now");
        chk(P_HCMD, 1, "R9"); chk(P_HV, 1, "R9");
        go(3);
        go(5);
        chk(P_FSHR, 0, "R9 shared cleared");
        go(6);
        go(0);
        chk(P_HORD, 7, "R12 order");
        go(6);
        go(8);
        chk(P_ERR, 0, "R10");
        idle_chk_state(0, 0, "R10 freed");

        // B: exclusive snoop before issue rewrites upgrades
        go(1, .cmd(2), .ord(1));
        go(4, .scmd(1));
        chk(P_HIT, 0, "R5"); chk(P_INH, 0, "R5");
        idle_chk_state(1, 1, "R5 no append");
        go(3); go(5);
        go(0);
        chk(P_HCMD, 1, "R5 rewritten");
        go(6); go(8);
        idle_chk_state(0, 0, "R10");

        // C: exclusive snoop in service, pending invalidate
        go(1, .cmd(0), .ord(1));
        go(3);
        go(2, .cmd(2), .ord(2), .rdy(40));
        go(4, .scmd(1), .ord(9));
        chk(P_HIT, 1, "R7"); chk(P_INH, 0, "R7"); chk(P_SUP, 0, "R7");
        idle_chk_state(2, 3, "R7 append");
        go(4, .scmd(0));
        chk(P_HIT, 1, "R6 absorbed"); chk(P_SHR, 0, "R6 absorbed");
        idle_chk_state(2, 3, "R6 no append");
        go(2, .cmd(0), .ord(3));
        go(5);
        go(0);
        chk(P_HORD, 1, "R12");
        go(6);
        go(0);
        chk(P_HCMD, 1, "R7 copy"); chk(P_HCPU, 0, "R7 copy"); chk(P_HORD, 9, "R7 copy");
        go(6);
        go(0);
        chk(P_HV, 0, "R2 pinv defers"); chk(P_CNT, 2, "R2 pinv defers");
        go(7, .nw(0));
        go(0);
        chk(P_HCMD, 1, "R6 deferred rewritten"); chk(P_ORD, 2, "R9");
        chk(P_RDY, 40, "R9 max head");
        go(3); go(5); go(6); go(6); go(8);
        idle_chk_state(0, 0, "R10");

        // D: primary needs exclusive
        go(1, .cmd(2), .ord(1));
        go(3);
        go(4, .scmd(0), .ord(10));
        chk(P_HIT, 1, "R7"); chk(P_INH, 1, "R7"); chk(P_SUP, 1, "R7"); chk(P_SHR, 0, "R7");
        go(4, .scmd(1), .ord(11));
        chk(P_INH, 1, "R7"); chk(P_SUP, 1, "R7");
        idle_chk_state(2, 3, "R7");
        go(5);
        go(0);
        chk(P_HCMD, 2, "R6 primary kept");
        go(6); go(6); go(6); go(8);
        idle_chk_state(0, 0, "R10");

        // E: express snoop with downstream pending
        go(1, .cmd(0), .ord(4));
        go(0, .dp(1));
        go(3);
        go(4, .scmd(0), .ex(1));
        chk(P_HIT, 0, "R11"); chk(P_SHR, 0, "R11");
        go(4, .scmd(0), .ex(0));
        chk(P_SHR, 1, "R8");
        go(5);
        chk(P_FSHR, 1, "R8");
        go(6); go(8);
        idle_chk_state(0, 0, "R10");

        // F: forward-only entries
        go(1, .cmd(3), .fw(1));
        go(3);
        chk(P_FREE, 1, "R4");
        idle_chk_state(0, 0, "R4");
        go(1, .cmd(3), .fw(1));
        go(2, .cmd(0));
        go(3);
        chk(P_FREE, 0, "R4 two targets");
        idle_chk_state(2, 2, "R4");
        go(5); go(6); go(6); go(8);
        idle_chk_state(0, 0, "R10");

        // G: full queue stalls
        go(1, .cmd(0));
        for (int i = 0; i < DEPTH - 1; i++) go(2, .cmd(0), .ord(i + 20));
        idle_chk_state(1, DEPTH, "R3 fill");
        go(2, .cmd(0), .ord(99));
        chk(P_STALL, 1, "R3");
        idle_chk_state(1, DEPTH, "R3 refused");
        go(3); go(5);
        for (int i = 0; i < DEPTH; i++) go(6);
        go(0);
        chk(P_HV, 0, "R3 nothing extra");
        go(8);
        idle_chk_state(0, 0, "R10");

        go(0); go(0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule